// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block keeps the 13-bit instruction pointer of a small microcontroller core and an eight-entry return-address stack beside it. Each cycle it takes an interrupt-entry strobe and a 3-bit operation code from the instruction decoder. The operation is one of hold, step, jump, call, or one of three return flavours. From these it produces the next fetch address. The logical space covers 8K words. The program store behind the block has only 1K words, so the fetch port carries the low ten bits of the pointer, and any pointer value above 03FFh folds back into that window.

Calls and interrupt entries push the address of the next sequential instruction. The three return flavours pop that address back. The decoder uses one of them when it also loads a literal into the working register, and another when it leaves an interrupt handler. That last flavour also raises a one-cycle strobe, which lets the interrupt-enable logic elsewhere switch interrupts back on. The stack is a ring: overflow and underflow wrap silently and raise no flag.

The reset input asserts asynchronously. Its release is taken in through a two-stage synchronizer inside the block.

Top module: `pc_stack_unit`

## Requirements
- R1: While reset is low, the pointer is 0000h, every stack slot holds 0000h, the stack depth counter is 0, and the return-from-interrupt strobe is low. After the reset input rises, operations are ignored on the first two rising clock edges and take effect from the third.
- R2: The fetch address always equals bits 9:0 of the 13-bit pointer. A pointer above 03FFh therefore fetches from inside the first 1K words.
- R3: Operation code 1 (step) sets the pointer to the pointer plus one, modulo 8192, so 1FFFh steps to 0000h.
- R4: Operation code 2 (jump) loads the 13-bit target input into the pointer and leaves the stack unchanged.
- R5: Operation code 3 (call) pushes the pointer plus one, modulo 8192, and loads the target input.
- R6: When the interrupt strobe is high, the pointer plus one is pushed, the pointer becomes 0004h, and the operation code of that cycle is ignored.
- R7: Operation codes 4 (plain return), 5 (return from interrupt) and 6 (return with literal) each pop the most recently pushed address into the pointer, in last-in first-out order.
- R8: The stack holds eight 13-bit entries in a ring. A ninth push without a pop overwrites the oldest entry. A pop from an empty stack returns the slot that the wrapped pointer selects.
- R9: The return-from-interrupt strobe is high for exactly the one cycle that follows a clock edge on which operation code 5 was honoured, and low at all other times.
- R10: Operation codes 0 (hold) and 7 (reserved) leave the pointer and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| irq_take_i | input | 1 | Interrupt entry strobe; takes priority over the operation code |
| op_i | input | 3 | Operation code: 0 hold, 1 step, 2 jump, 3 call, 4 return, 5 return from interrupt, 6 return with literal, 7 reserved |
| target_i | input | 13 | Jump or call destination |
| pc_o | output | 13 | Current 13-bit instruction pointer |
| fetch_addr_o | output | 10 | Address into the 1K-word program store |
| retfie_pulse_o | output | 1 | One-cycle strobe after a return from interrupt |

## Verification
Directed sequences come first. A jump to 1FFFh followed by a step separates a 13-bit wrap from a 10-bit one. A jump to 0405h shows that the fetch port folds into the 1K window while the pointer keeps all 13 bits. Nine calls followed by ten returns show whether the oldest entry is overwritten and how an empty pop wraps. An interrupt strobe that coincides with a call shows that the interrupt wins and the call is dropped.

Constrained-random cycles follow, mixing all eight codes with sparse interrupts. The bench model holds its own ring, so wrong push data, a wrong pop order or a misplaced return strobe shows up as a pointer that diverges from the model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_INC    = 3'd1,
    OP_JUMP   = 3'd2,
    OP_CALL   = 3'd3,
    OP_RET    = 3'd4,
    OP_RETFIE = 3'd5,
    OP_RETLW  = 3'd6,
    OP_RSVD   = 3'd7
  } pcs_op_e;

  typedef enum logic [2:0] {
    ACT_KEEP   = 3'd0,
    ACT_STEP   = 3'd1,
    ACT_TARGET = 3'd2,
    ACT_VECTOR = 3'd3,
    ACT_POP    = 3'd4
  } pcs_act_e;

  typedef struct packed {
    pcs_act_e act;
    logic     push;
    logic     pop;
    logic     retfie;
  } pcs_ctl_t;

endpackage

// File: rtl/pcs_rst_sync.sv
module pcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a constant one in; assertion is asynchronous, release is clocked.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic       irq_take_i,
  input  logic [2:0] op_i,
  output pcs_ctl_t   ctl_o
);
  pcs_op_e op;

  always_comb begin
    op    = pcs_op_e'(op_i);
    ctl_o = '{act: ACT_KEEP, push: 1'b0, pop: 1'b0, retfie: 1'b0};
    if (irq_take_i) begin
      // Interrupt entry outranks any decoded operation.
      ctl_o.act  = ACT_VECTOR;
      ctl_o.push = 1'b1;
    end else begin
      unique case (op)
        OP_INC:  ctl_o.act = ACT_STEP;
        OP_JUMP: ctl_o.act = ACT_TARGET;
        OP_CALL: begin
          ctl_o.act  = ACT_TARGET;
          ctl_o.push = 1'b1;
        end
        OP_RET, OP_RETLW: begin
          ctl_o.act = ACT_POP;
          ctl_o.pop = 1'b1;
        end
        OP_RETFIE: begin
          ctl_o.act    = ACT_POP;
          ctl_o.pop    = 1'b1;
          ctl_o.retfie = 1'b1;
        end
        OP_HOLD, OP_RSVD: ctl_o.act = ACT_KEEP;
        default:          ctl_o.act = ACT_KEEP;
      endcase
    end
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o
);
  // DEPTH must be a power of two so the pointer wraps by itself.
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    ptr_q;
  logic [PW-1:0]    ptr_d;
  logic [PW-1:0]    top_idx;
  logic [DEPTH-1:0] wr_en;

  always_comb begin
    ptr_d = ptr_q;
    if (push_i)     ptr_d = ptr_q + PW'(1);
    else if (pop_i) ptr_d = ptr_q - PW'(1);
    top_idx = ptr_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign wr_en[g] = push_i && (ptr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q[g] <= '0;
      else if (wr_en[g]) slot_q[g] <= push_data_i;
    end
  end

  assign top_o = slot_q[top_idx];
endmodule

// File: rtl/pcs_counter.sv
module pcs_counter
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W      = 13,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pcs_ctl_t        ctl_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [PC_W-1:0] pop_data_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] ret_addr_o,
  output logic            retfie_pulse_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;
  logic            pulse_q, pulse_d;

  assign ret_addr_o = pc_q + PC_W'(1);

  always_comb begin
    pc_en = (ctl_i.act != ACT_KEEP);
    unique case (ctl_i.act)
      ACT_STEP:   pc_d = ret_addr_o;
      ACT_TARGET: pc_d = target_i;
      ACT_VECTOR: pc_d = IRQ_VEC;
      ACT_POP:    pc_d = pop_data_i;
      default:    pc_d = pc_q;
    endcase
    pulse_d = ctl_i.retfie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RST_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pc_o           = pc_q;
  assign retfie_pulse_o = pulse_q;
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W        = 13,
  parameter int unsigned PHYS_W      = 10,
  parameter int unsigned STACK_DEPTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take_i,
  input  logic [2:0]        op_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PHYS_W-1:0] fetch_addr_o,
  output logic              retfie_pulse_o
);
  localparam logic [PC_W-1:0] RST_VEC = '0;
  localparam logic [PC_W-1:0] IRQ_VEC = PC_W'(4);

  logic            rst_sync_n;
  pcs_ctl_t        ctl;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] top_data;

  pcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pcs_arbiter u_arb (
    .irq_take_i (irq_take_i),
    .op_i       (op_i),
    .ctl_o      (ctl)
  );

  pcs_ret_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PC_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_i      (ctl.push),
    .pop_i       (ctl.pop),
    .push_data_i (ret_addr),
    .top_o       (top_data)
  );

  pcs_counter #(.PC_W(PC_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_pc (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .ctl_i          (ctl),
    .target_i       (target_i),
    .pop_data_i     (top_data),
    .pc_o           (pc_o),
    .ret_addr_o     (ret_addr),
    .retfie_pulse_o (retfie_pulse_o)
  );

  // Only the low window of the program store exists; high bits fold away.
  assign fetch_addr_o = pc_o[PHYS_W-1:0];
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pcs_pkg::*;
#(
  parameter int unsigned PC_W   = 13,
  parameter int unsigned PHYS_W = 10
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              irq_take_i,
  input logic [2:0]        op_i,
  input logic [PC_W-1:0]   target_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [PHYS_W-1:0] fetch_addr_o,
  input logic              retfie_pulse_o
);
  assert_fetch_window_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_addr_o == pc_o[PHYS_W-1:0]);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_take_i && op_i == OP_INC) |=> pc_o == $past(pc_o) + PC_W'(1));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_take_i && (op_i == OP_JUMP || op_i == OP_CALL)) |=> pc_o == $past(target_i));

  assert_irq_vector_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_take_i |=> pc_o == PC_W'(4));

  assert_pulse_set_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_take_i && op_i == OP_RETFIE) |=> retfie_pulse_o);

  assert_pulse_clr_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_take_i || op_i != OP_RETFIE) |=> !retfie_pulse_o);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_take_i && (op_i == OP_HOLD || op_i == OP_RSVD)) |=> $stable(pc_o));
endmodule

bind pc_stack_unit pcs_checker #(.PC_W(PC_W), .PHYS_W(PHYS_W)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .irq_take_i     (irq_take_i),
  .op_i           (op_i),
  .target_i       (target_i),
  .pc_o           (pc_o),
  .fetch_addr_o   (fetch_addr_o),
  .retfie_pulse_o (retfie_pulse_o)
);

// File: tb/tb_pc_stack_unit.sv
`timescale 1ns/1ps
module tb_pc_stack_unit;
  logic        clk;
  logic        rst_n;
  logic        irq;
  logic [2:0]  op;
  logic [12:0] tgt;
  logic [12:0] pc;
  logic [9:0]  fa;
  logic        pulse;

  int unsigned n_chk;
  int unsigned n_err;
  int unsigned cyc_cnt;

  logic [12:0] m_stk [8];
  logic [2:0]  m_ptr;
  logic [12:0] m_pc;
  logic        m_pulse;

  pc_stack_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_take_i(irq), .op_i(op), .target_i(tgt),
    .pc_o(pc), .fetch_addr_o(fa), .retfie_pulse_o(pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic i, input logic [2:0] o);
    if (i) return "R6";
    case (o)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd6: return "R7";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Bench model of one honoured cycle.
  task automatic model_step(input logic i, input logic [2:0] o, input logic [12:0] t);
    logic [12:0] nxt;
    nxt = m_pc + 13'd1;
    m_pulse = 1'b0;
    if (i) begin
      m_stk[m_ptr] = nxt; m_ptr = m_ptr + 3'd1; m_pc = 13'd4;
    end else begin
      case (o)
        3'd1: m_pc = nxt;
        3'd2: m_pc = t;
        3'd3: begin m_stk[m_ptr] = nxt; m_ptr = m_ptr + 3'd1; m_pc = t; end
        3'd4, 3'd5, 3'd6: begin
          m_ptr = m_ptr - 3'd1; m_pc = m_stk[m_ptr];
          m_pulse = (o == 3'd5);
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(input logic i, input logic [2:0] o, input logic [12:0] t, input string tag);
    irq = i; op = o; tgt = t;
    @(posedge clk); #2;
    model_step(i, o, t);
    chk(tag, {19'd0, pc}, {19'd0, m_pc});
    chk("R2", {22'd0, fa}, {22'd0, m_pc[9:0]});
    chk((o == 3'd5 && !i) ? "R9" : "R9_low", {31'd0, pulse}, {31'd0, m_pulse});
  endtask

  initial begin
    cyc_cnt = 0;
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; irq = 1'b0; op = 3'd0; tgt = '0;
    for (int k = 0; k < 8; k++) m_stk[k] = '0;
    m_ptr = '0; m_pc = '0; m_pulse = 1'b0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", {19'd0, pc}, 32'd0);
    chk("R1", {31'd0, pulse}, 32'd0);
    // R1: release; ops on the first two edges must be ignored.
    @(negedge clk); rst_n = 1'b1; irq = 1'b0; op = 3'd2; tgt = 13'h0123;
    @(posedge clk); @(posedge clk); #2;
    chk("R1", {19'd0, pc}, 32'd0);
    op = 3'd0;
    // R8 underflow straight after reset reads a cleared slot.
    step(1'b0, 3'd4, '0, "R8");
    step(1'b0, 3'd0, '0, "R10");
    // R3 13-bit wrap.
    step(1'b0, 3'd2, 13'h1FFF, "R4");
    step(1'b0, 3'd1, '0, "R3");
    chk("R3", {19'd0, pc}, 32'd0);
    // R2 fold above 1K.
    step(1'b0, 3'd2, 13'h0405, "R2");
    chk("R2", {22'd0, fa}, 32'h005);
    step(1'b0, 3'd7, 13'h0AAA, "R10");
    // R6 interrupt beats a call.
    step(1'b1, 3'd3, 13'h0777, "R6");
    chk("R6", {19'd0, pc}, 32'h4);
    step(1'b0, 3'd1, '0, "R3");
    step(1'b0, 3'd5, '0, "R9");
    chk("R7", {19'd0, pc}, 32'h0406);
    chk("R9", {31'd0, pulse}, 32'd1);
    step(1'b0, 3'd0, '0, "R9");
    chk("R9", {31'd0, pulse}, 32'd0);
    // R8 nine calls then ten returns.
    for (int k = 0; k < 9; k++) step(1'b0, 3'd3, 13'(16'h0100 * (k + 1)), "R5");
    for (int k = 0; k < 10; k++) step(1'b0, (k % 2 == 0) ? 3'd4 : 3'd6, '0, "R8");
    // Random mix.
    for (int k = 0; k < 4000; k++) begin
      logic        ri;
      logic [2:0]  ro;
      logic [12:0] rt;
      ri = ($urandom_range(0, 15) == 0);
      ro = 3'($urandom_range(0, 7));
      rt = 13'($urandom);
      step(ri, ro, rt, tag_of(ri, ro));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule